// File: doc/BRIEF.md
# Cross-Port Mailbox Interrupt Controller

This block sits beside a two-port shared memory and turns the two highest addresses of that memory into mailbox doorbells. Port A and port B each see the same address space. When one port writes into the mailbox word that belongs to the opposite port, a pending flag is set for that opposite port. The flag appears as an active-low interrupt output. The receiving port acknowledges the interrupt by accessing its own mailbox word. The word at the top address belongs to port B. The word one below it belongs to port A.

The block only watches the port control and address lines. The 16-bit contents of both mailbox words stay in the ordinary memory array. When the feature enable input is low, no flag changes, so the two top words behave as plain memory. Both flags are registered and update on the clock edge that follows the access that triggers them.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, both `irq_a_n` and `irq_b_n` are high (deasserted), and they stay high after reset until a raising access occurs.
- R2: A port B write (`b_sel_n`=0, `b_wr_n`=0) to address 0xFFFE while `mbx_en`=1 drives `irq_a_n` low from the next rising clock edge.
- R3: A port A write (`a_sel_n`=0, `a_wr_n`=0) to address 0xFFFF while `mbx_en`=1 drives `irq_b_n` low from the next rising clock edge.
- R4: Port A clears its interrupt by accessing 0xFFFE with `a_sel_n`=0 and `a_oe_n`=0, whatever the level of `a_wr_n`. `irq_a_n` returns high from the next edge.
- R5: Port B clears its interrupt only by reading 0xFFFF (`b_sel_n`=0, `b_oe_n`=0, `b_wr_n`=1). A port B write to 0xFFFF with `b_oe_n`=0 leaves `irq_b_n` unchanged.
- R6: When a raising access and a clearing access for the same flag occur in the same clock, the flag ends up set (interrupt low).
- R7: While `mbx_en`=0, neither flag changes, whatever the access on either port.
- R8: The following accesses have no effect on the flags: accesses to other addresses, accesses with the port select high, a port writing its own mailbox word, and a port A access with `a_oe_n`=1.
- R9: Each interrupt output changes only at a rising clock edge and holds its level in any cycle that has neither a raising nor a clearing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbx_en | input | 1 | Mailbox interrupt feature enable |
| a_sel_n | input | 1 | Port A select, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_wr_n | input | 1 | Port A read/write: 1 read, 0 write |
| a_addr | input | 16 | Port A address |
| b_sel_n | input | 1 | Port B select, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_wr_n | input | 1 | Port B read/write: 1 read, 0 write |
| b_addr | input | 16 | Port B address |
| irq_a_n | output | 1 | Interrupt toward port A, active low |
| irq_b_n | output | 1 | Interrupt toward port B, active low |

## Verification
The internal state is only two pending bits, and each one is visible directly on an interrupt pin. A wrong state therefore shows at the ports one cycle after the access that caused it. Decode errors show the same way. Examples are a mailbox address that is off by one, a clear condition that ignores the read/write level, or swapped raise paths. Each of these appears as an interrupt that falls or rises on the wrong edge. A fault in priority or enable gating only shows when a raise and a clear happen together, or while the feature is off. The sweep below applies every control combination on both ports at once against addresses on and near the mailbox words, so the pins are compared after every such coincidence.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

  // Control lines of one port, all active low except the read/write level.
  typedef struct packed {
    logic sel_n;
    logic oe_n;
    logic wr_n;
  } mbx_ctl_t;

  // How a port acknowledges its own mailbox word.
  typedef enum logic {
    CLR_ON_ACCESS = 1'b0,
    CLR_ON_READ   = 1'b1
  } mbx_clr_mode_e;

  function automatic logic ctl_is_write(mbx_ctl_t c);
    return !c.sel_n && !c.wr_n;
  endfunction

  function automatic logic ctl_is_access(mbx_ctl_t c);
    return !c.sel_n && !c.oe_n;
  endfunction

  function automatic logic ctl_is_read(mbx_ctl_t c);
    return !c.sel_n && !c.oe_n && c.wr_n;
  endfunction

  // Next pending value: a raise dominates a clear.
  function automatic logic pending_next(logic cur, logic raise, logic clear);
    return raise | (cur & ~clear);
  endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_irq_pkg::*;
#(
  parameter int            ADDR_W    = 16,
  parameter mbx_clr_mode_e CLR_MODE  = CLR_ON_ACCESS,
  parameter logic [ADDR_W-1:0] OWN_ADDR  = '1,
  parameter logic [ADDR_W-1:0] PEER_ADDR = '1
) (
  input  mbx_ctl_t          ctl,
  input  logic [ADDR_W-1:0] addr,
  output logic              raise_peer,
  output logic              clear_own
);

  logic own_hit;
  logic peer_hit;
  logic ack_cycle;

  assign own_hit  = (addr == OWN_ADDR);
  assign peer_hit = (addr == PEER_ADDR);

  // Raising the opposite port: any write to the opposite port's word.
  assign raise_peer = ctl_is_write(ctl) && peer_hit;

  generate
    if (CLR_MODE == CLR_ON_READ) begin : g_clr_read
      assign ack_cycle = ctl_is_read(ctl);
    end else begin : g_clr_access
      assign ack_cycle = ctl_is_access(ctl);
    end
  endgenerate

  assign clear_own = ack_cycle && own_hit;

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
  import mbx_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic raise,
  input  logic clear,
  output logic irq_n
);

  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (en) begin
      pending <= pending_next(pending, raise, clear);
    end
  end

  assign irq_n = ~pending;

  // R6
  raise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && raise) |=> !irq_n);

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clear && !raise) |=> irq_n);

  // R7
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(irq_n));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise && !clear) |=> $stable(irq_n));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mbx_en,
  input  logic              a_sel_n,
  input  logic              a_oe_n,
  input  logic              a_wr_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_sel_n,
  input  logic              b_oe_n,
  input  logic              b_wr_n,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              irq_a_n,
  output logic              irq_b_n
);

  localparam int NPORT = 2;
  localparam logic [ADDR_W-1:0] MBX_B_ADDR = '1;
  localparam logic [ADDR_W-1:0] MBX_A_ADDR = MBX_B_ADDR - 1'b1;

  mbx_ctl_t          port_ctl  [NPORT];
  logic [ADDR_W-1:0] port_addr [NPORT];
  logic [NPORT-1:0]  raise_peer;
  logic [NPORT-1:0]  clear_own;
  logic [NPORT-1:0]  irq_n_vec;

  assign port_ctl[0]  = '{sel_n: a_sel_n, oe_n: a_oe_n, wr_n: a_wr_n};
  assign port_ctl[1]  = '{sel_n: b_sel_n, oe_n: b_oe_n, wr_n: b_wr_n};
  assign port_addr[0] = a_addr;
  assign port_addr[1] = b_addr;

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      mbx_port_decode #(
        .ADDR_W   (ADDR_W),
        .CLR_MODE ((p == 0) ? CLR_ON_ACCESS : CLR_ON_READ),
        .OWN_ADDR ((p == 0) ? MBX_A_ADDR : MBX_B_ADDR),
        .PEER_ADDR((p == 0) ? MBX_B_ADDR : MBX_A_ADDR)
      ) u_dec (
        .ctl       (port_ctl[p]),
        .addr      (port_addr[p]),
        .raise_peer(raise_peer[p]),
        .clear_own (clear_own[p])
      );

      mbx_flag u_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (mbx_en),
        .raise(raise_peer[NPORT-1-p]),
        .clear(clear_own[p]),
        .irq_n(irq_n_vec[p])
      );
    end
  endgenerate

  assign irq_a_n = irq_n_vec[0];
  assign irq_b_n = irq_n_vec[1];

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (irq_a_n && irq_b_n));

  // R2
  a_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_a_n) |-> $past(mbx_en && !b_sel_n && !b_wr_n && (b_addr == MBX_A_ADDR)));

  // R3
  b_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_b_n) |-> $past(mbx_en && !a_sel_n && !a_wr_n && (a_addr == MBX_B_ADDR)));

  // R5
  b_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_b_n) |-> $past(!b_sel_n && !b_oe_n && b_wr_n && (b_addr == MBX_B_ADDR)));

  // R4
  a_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_a_n) |-> $past(!a_sel_n && !a_oe_n && (a_addr == MBX_A_ADDR)));

endmodule

// File: tb/mbx_irq_ctrl_bench.sv
`timescale 1ns/1ps
module mbx_irq_ctrl_bench;

  localparam int AW = 16;
  localparam logic [AW-1:0] MB_A = 16'hFFFE;
  localparam logic [AW-1:0] MB_B = 16'hFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mbx_en = 1'b0;
  logic a_sel_n = 1'b1, a_oe_n = 1'b1, a_wr_n = 1'b1;
  logic b_sel_n = 1'b1, b_oe_n = 1'b1, b_wr_n = 1'b1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic irq_a_n, irq_b_n;

  int checks = 0;
  int errors = 0;
  logic exp_a = 1'b0;  // expected pending toward A
  logic exp_b = 1'b0;  // expected pending toward B

  always #2.5 clk = ~clk;

  mbx_irq_ctrl #(.ADDR_W(AW)) u_mbx_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .mbx_en(mbx_en),
    .a_sel_n(a_sel_n), .a_oe_n(a_oe_n), .a_wr_n(a_wr_n), .a_addr(a_addr),
    .b_sel_n(b_sel_n), .b_oe_n(b_oe_n), .b_wr_n(b_wr_n), .b_addr(b_addr),
    .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
  );

  task automatic check_pin(string tag, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
    end
  endtask

  // Drive one cycle of stimulus at a falling edge, update the model at
  // the rising edge and compare at the next falling edge.
  task automatic step(string tag, logic en,
                      logic as, logic ao, logic aw, logic [AW-1:0] aa,
                      logic bs, logic bo, logic bw, logic [AW-1:0] ba);
    logic up_a, dn_a, up_b, dn_b;
    mbx_en = en;
    a_sel_n = as; a_oe_n = ao; a_wr_n = aw; a_addr = aa;
    b_sel_n = bs; b_oe_n = bo; b_wr_n = bw; b_addr = ba;
    up_a = (bs == 1'b0) && (bw == 1'b0) && (ba == MB_A);
    dn_a = (as == 1'b0) && (ao == 1'b0) && (aa == MB_A);
    up_b = (as == 1'b0) && (aw == 1'b0) && (aa == MB_B);
    dn_b = (bs == 1'b0) && (bo == 1'b0) && (bw == 1'b1) && (ba == MB_B);
    @(posedge clk);
    if (en) begin
      if (up_a) exp_a = 1'b1;
      else if (dn_a) exp_a = 1'b0;
      if (up_b) exp_b = 1'b1;
      else if (dn_b) exp_b = 1'b0;
    end
    @(negedge clk);
    check_pin(tag, "irq_a_n", irq_a_n, ~exp_a);
    check_pin(tag, "irq_b_n", irq_b_n, ~exp_b);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b1, 1'b1, 1'b1, '0);
  endtask

  function automatic logic [AW-1:0] addr_of(int k);
    case (k)
      0: return MB_A;
      1: return MB_B;
      2: return 16'hFFFD;
      default: return 16'h7FFF;
    endcase
  endfunction

  function automatic string tag_of(logic en, logic [2:0] ac, logic [AW-1:0] aa,
                                   logic [2:0] bc, logic [AW-1:0] ba);
    logic up_a, dn_a, up_b, dn_b;
    up_a = !bc[2] && !bc[0] && (ba == MB_A);
    dn_a = !ac[2] && !ac[1] && (aa == MB_A);
    up_b = !ac[2] && !ac[0] && (aa == MB_B);
    dn_b = !bc[2] && !bc[1] && bc[0] && (ba == MB_B);
    if (!en) return "R7";
    if ((up_a && dn_a) || (up_b && dn_b)) return "R6";
    if (up_a) return "R2";
    if (up_b) return "R3";
    if (dn_a) return "R4";
    if (dn_b) return "R5";
    return "R8";
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R1: outputs deasserted during and after reset
    repeat (3) @(negedge clk);
    check_pin("R1", "irq_a_n", irq_a_n, 1'b1);
    check_pin("R1", "irq_b_n", irq_b_n, 1'b1);
    rst_n = 1'b1;
    idle("R1");

    // R2 then R4 via a write access with oe low
    step("R2", 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b0, 1'b1, 1'b0, MB_A);
    idle("R9");
    step("R8", 1'b1, 1'b0, 1'b1, 1'b1, MB_A, 1'b1, 1'b1, 1'b1, '0);  // oe high
    step("R4", 1'b1, 1'b0, 1'b0, 1'b0, MB_A, 1'b1, 1'b1, 1'b1, '0);
    // R3 then R5: write with oe low does not clear, read does
    step("R3", 1'b1, 1'b0, 1'b1, 1'b0, MB_B, 1'b1, 1'b1, 1'b1, '0);
    step("R5", 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b0, 1'b0, 1'b0, MB_B);
    step("R5", 1'b1, 1'b1, 1'b1, 1'b1, '0, 1'b0, 1'b0, 1'b1, MB_B);
    // R8: own-word writes do not raise own flag
    step("R8", 1'b1, 1'b0, 1'b1, 1'b0, MB_A, 1'b0, 1'b1, 1'b0, MB_B);
    // R6: raise and clear of flag A together
    step("R6", 1'b1, 1'b0, 1'b0, 1'b1, MB_A, 1'b0, 1'b1, 1'b0, MB_A);
    // R7: disabled, clear attempt ignored, raise attempt ignored
    step("R7", 1'b0, 1'b0, 1'b0, 1'b1, MB_A, 1'b1, 1'b1, 1'b1, '0);
    step("R7", 1'b0, 1'b0, 1'b1, 1'b0, MB_B, 1'b1, 1'b1, 1'b1, '0);
    // R1: reset in the middle clears a pending flag
    rst_n = 1'b0;
    exp_a = 1'b0; exp_b = 1'b0;
    @(negedge clk);
    check_pin("R1", "irq_a_n", irq_a_n, 1'b1);
    check_pin("R1", "irq_b_n", irq_b_n, 1'b1);
    rst_n = 1'b1;
    idle("R1");

    // Sweep: every control combination on both ports, several addresses
    for (int en = 1; en >= 0; en--) begin
      for (int ac = 0; ac < 8; ac++) begin
        for (int ak = 0; ak < 4; ak++) begin
          for (int bc = 0; bc < 8; bc++) begin
            for (int bk = 0; bk < 4; bk++) begin
              step(tag_of(en[0], ac[2:0], addr_of(ak), bc[2:0], addr_of(bk)),
                   en[0], ac[2], ac[1], ac[0], addr_of(ak),
                   bc[2], bc[1], bc[0], addr_of(bk));
            end
          end
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule